// File: doc/BRIEF.md
# Prescaled Timer/Counter with Match and Capture Channels

This block is a 32-bit timer/counter for a peripheral subsystem. In timer mode a programmable 32-bit prescaler divides the system clock and the count advances once per prescaler period. In counter mode the prescaler is bypassed and the count advances on edges of an external, asynchronous count input.

Four match channels compare their registers with the count. On a hit, a channel can reset the count to zero, stop it, raise an interrupt flag, and drive its match output low, high, toggled or unchanged. Four capture channels synchronize their inputs, detect the selected edges and store the current count, optionally raising an interrupt flag. Software reaches every register through a single-cycle write port and a registered read port. The interrupt line is the OR of all pending flags.

Top module: `ptimer_top`

## Requirements
- R1: After synchronous reset every register, the count, the prescale counter, all match outputs and `irq` read 0.
- R2: In timer mode (MODE bit0 = 0), with the prescale register at P, the prescale counter runs 0..P and the count advances by one on each clock where the prescale counter wraps, once every P+1 enabled clocks.
- R3: In counter mode (MODE bit0 = 1), `count_in` passes through a two-flop synchronizer. The count advances once per rising edge, or per falling edge when MODE bit1 = 1. The prescale counter stays 0.
- R4: CTRL bit0 enables counting. While CTRL bit1 is 1, the count and prescale counter are held at 0.
- R5: A match channel with reset selected makes the count return to 0 on the advance after the count equals its match value, so the count period is the match value plus one.
- R6: A match channel with stop selected clears CTRL bit0 on a hit, and the count holds the match value. A stop takes priority over a CTRL write in the same cycle.
- R7: MATCH_CFG gives channel i bits [5i+4:5i]: bit0 interrupt, bit1 reset, bit2 stop, bits[4:3] output action (00 none, 01 drive low, 10 drive high, 11 toggle). A hit is the advance that leaves the matching value, and it applies the action to `mat_out[i]`.
- R8: A hit on match channel i with its interrupt bit set sets FLAGS bit i. With the interrupt bit clear, no flag is set.
- R9: CAP_CFG gives channel j bits [3j+2:3j]: bit0 capture on rising edge, bit1 on falling edge (both for either edge), bit2 interrupt. A selected edge on `cap_in[j]`, after two-flop synchronization, copies the count into capture register j. Other edges leave it unchanged.
- R10: A capture with its interrupt bit set sets FLAGS bit 4+j. With the interrupt bit clear, no flag is set.
- R11: Writing FLAGS clears each bit written as 1 and leaves bits written as 0. A new event in the same cycle wins. `irq` is 1 exactly when any flag is 1.
- R12: Word addresses: 0 CTRL, 1 MODE, 2 PRESCALE, 3 prescale counter (read), 4 count (read), 5 FLAGS, 6 MATCH_CFG, 7 CAP_CFG, 8-11 match values, 12-15 capture registers (read). `bus_rdata` shows the register addressed at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| count_in | input | 1 | External count input, asynchronous |
| cap_in | input | 4 | Capture inputs, asynchronous |
| mat_out | output | 4 | Match outputs |
| irq | output | 1 | Interrupt, OR of pending flags |

## Verification
The assertions check the cycle-level invariants on every clock:
- the count steps only by one, to zero or not at all;
- the hold bit forces both counters to zero;
- a stop clears the enable;
- match outputs and capture registers change only on their own events;
- an enabled match raises `irq`.

Only the directed scenarios can show the exact division ratios, reset-on-match periods, counter-mode edge counting, the final state of each output action, capture edge selection with real count values, and write-one-to-clear behaviour.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } mact_e;

  typedef struct packed {
    mact_e act;
    logic  stop;
    logic  rst;
    logic  irq;
  } mcfg_t;

  typedef struct packed {
    logic irq;
    logic fall;
    logic rise;
  } ccfg_t;

  localparam int MCFG_W = $bits(mcfg_t);
  localparam int CCFG_W = $bits(ccfg_t);

  localparam int A_CTRL    = 0;
  localparam int A_MODE    = 1;
  localparam int A_PRESC   = 2;
  localparam int A_PCNT    = 3;
  localparam int A_COUNT   = 4;
  localparam int A_FLAGS   = 5;
  localparam int A_MCFG    = 6;
  localparam int A_CCFG    = 7;
  localparam int A_MR_BASE = 8;

endpackage

// File: rtl/ptimer_sync_edge.sv
module ptimer_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] sh;
  logic         prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[MSB-1:0], din};
      prev <= sh[MSB];
    end
  end

  assign rise = sh[MSB] & ~prev;
  assign fall = ~sh[MSB] & prev;
endmodule

// File: rtl/ptimer_core.sv
module ptimer_core #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          hold,
  input  logic          cnt_mode,
  input  logic          ext_edge,
  input  logic [TW-1:0] presc,
  input  logic          clr_req,
  input  logic          stop_req,
  output logic [TW-1:0] tc,
  output logic [TW-1:0] pc,
  output logic          tick
);
  logic run;
  logic pwrap;

  assign run   = en & ~hold;
  assign pwrap = (pc >= presc);
  assign tick  = run & (cnt_mode ? ext_edge : pwrap);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      pc <= '0;
      tc <= '0;
    end else if (en) begin
      if (cnt_mode || pwrap) pc <= '0;
      else                   pc <= pc + TW'(1);
      if (tick) begin
        if (clr_req)       tc <= '0;
        else if (!stop_req) tc <= tc + TW'(1);
      end
    end
  end
endmodule

// File: rtl/ptimer_match_ch.sv
module ptimer_match_ch
  import ptimer_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tc,
  input  logic          tick,
  input  logic [TW-1:0] mval,
  input  mcfg_t         cfg,
  output logic          hit,
  output logic          mout
);
  assign hit = tick & (tc == mval);

  always_ff @(posedge clk) begin
    if (rst) begin
      mout <= 1'b0;
    end else if (hit) begin
      case (cfg.act)
        ACT_LOW:    mout <= 1'b0;
        ACT_HIGH:   mout <= 1'b1;
        ACT_TOGGLE: mout <= ~mout;
        default:    mout <= mout;
      endcase
    end
  end
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptimer_pkg::*;
#(
  parameter int TW      = 32,
  parameter int AW      = 5,
  parameter int NMATCH  = 4,
  parameter int NCAP    = 4,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [TW-1:0]     bus_wdata,
  output logic [TW-1:0]     bus_rdata,
  input  logic              count_in,
  input  logic [NCAP-1:0]   cap_in,
  output logic [NMATCH-1:0] mat_out,
  output logic              irq
);
  localparam int FW        = NMATCH + NCAP;
  localparam int MCFG_BITS = MCFG_W * NMATCH;
  localparam int CCFG_BITS = CCFG_W * NCAP;
  localparam int CR_BASE   = A_MR_BASE + NMATCH;

  logic                 ctrl_en, ctrl_hold;
  logic                 mode_cnt, mode_fall;
  logic [TW-1:0]        presc_q;
  logic [MCFG_BITS-1:0] mcfg_q;
  logic [CCFG_BITS-1:0] ccfg_q;
  logic [TW-1:0]        mr_q [NMATCH];
  logic [TW-1:0]        cr_q [NCAP];
  logic [FW-1:0]        flags_q;
  logic [FW-1:0]        flag_set;
  logic [TW-1:0]        tc, pc;
  logic                 tick;
  logic [NMATCH-1:0]    hit, m_rst, m_stop, m_irq;
  logic [NCAP-1:0]      cap_evt, c_irq;
  logic                 clr_any, stop_any;
  logic                 cnt_rise, cnt_fall;
  logic [TW*NCAP-1:0]   cr_flat;
  logic [TW-1:0]        rd_mux;

  function automatic logic hit_addr(input logic [AW-1:0] a, input int idx);
    return a == AW'(idx);
  endfunction

  // control and configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en   <= 1'b0;
      ctrl_hold <= 1'b0;
      mode_cnt  <= 1'b0;
      mode_fall <= 1'b0;
      presc_q   <= '0;
      mcfg_q    <= '0;
      ccfg_q    <= '0;
    end else begin
      if (bus_wr && hit_addr(bus_addr, A_CTRL)) begin
        ctrl_en   <= bus_wdata[0];
        ctrl_hold <= bus_wdata[1];
      end
      if (stop_any) ctrl_en <= 1'b0;
      if (bus_wr && hit_addr(bus_addr, A_MODE)) begin
        mode_cnt  <= bus_wdata[0];
        mode_fall <= bus_wdata[1];
      end
      if (bus_wr && hit_addr(bus_addr, A_PRESC)) presc_q <= bus_wdata;
      if (bus_wr && hit_addr(bus_addr, A_MCFG))  mcfg_q  <= bus_wdata[MCFG_BITS-1:0];
      if (bus_wr && hit_addr(bus_addr, A_CCFG))  ccfg_q  <= bus_wdata[CCFG_BITS-1:0];
    end
  end

  // counter input edge detection
  ptimer_sync_edge #(.STAGES(SYNC_ST)) u_cnt_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (count_in),
    .rise (cnt_rise),
    .fall (cnt_fall)
  );

  ptimer_core #(.TW(TW)) u_core (
    .clk      (clk),
    .rst      (rst),
    .en       (ctrl_en),
    .hold     (ctrl_hold),
    .cnt_mode (mode_cnt),
    .ext_edge (mode_fall ? cnt_fall : cnt_rise),
    .presc    (presc_q),
    .clr_req  (clr_any),
    .stop_req (stop_any),
    .tc       (tc),
    .pc       (pc),
    .tick     (tick)
  );

  // match channels
  for (genvar i = 0; i < NMATCH; i++) begin : g_match
    mcfg_t cfg_i;
    assign cfg_i     = mcfg_t'(mcfg_q[MCFG_W*i +: MCFG_W]);
    assign m_rst[i]  = cfg_i.rst;
    assign m_stop[i] = cfg_i.stop;
    assign m_irq[i]  = cfg_i.irq;

    always_ff @(posedge clk) begin
      if (rst)                                          mr_q[i] <= '0;
      else if (bus_wr && hit_addr(bus_addr, A_MR_BASE + i)) mr_q[i] <= bus_wdata;
    end

    ptimer_match_ch #(.TW(TW)) u_mch (
      .clk  (clk),
      .rst  (rst),
      .tc   (tc),
      .tick (tick),
      .mval (mr_q[i]),
      .cfg  (cfg_i),
      .hit  (hit[i]),
      .mout (mat_out[i])
    );
  end

  assign clr_any  = |(hit & m_rst);
  assign stop_any = |(hit & m_stop);

  // capture channels
  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    ccfg_t cfg_j;
    logic  c_rise, c_fall;
    assign cfg_j = ccfg_t'(ccfg_q[CCFG_W*j +: CCFG_W]);

    ptimer_sync_edge #(.STAGES(SYNC_ST)) u_csync (
      .clk  (clk),
      .rst  (rst),
      .din  (cap_in[j]),
      .rise (c_rise),
      .fall (c_fall)
    );

    assign cap_evt[j] = (c_rise & cfg_j.rise) | (c_fall & cfg_j.fall);
    assign c_irq[j]   = cfg_j.irq;

    always_ff @(posedge clk) begin
      if (rst)             cr_q[j] <= '0;
      else if (cap_evt[j]) cr_q[j] <= tc;
    end

    assign cr_flat[TW*j +: TW] = cr_q[j];
  end

  // interrupt flags, write one to clear, new events win
  assign flag_set = {cap_evt & c_irq, hit & m_irq};

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (bus_wr && hit_addr(bus_addr, A_FLAGS)) begin
      flags_q <= (flags_q & ~bus_wdata[FW-1:0]) | flag_set;
    end else begin
      flags_q <= flags_q | flag_set;
    end
  end

  assign irq = |flags_q;

  // registered read port
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(A_CTRL):  rd_mux = TW'({ctrl_hold, ctrl_en});
      AW'(A_MODE):  rd_mux = TW'({mode_fall, mode_cnt});
      AW'(A_PRESC): rd_mux = presc_q;
      AW'(A_PCNT):  rd_mux = pc;
      AW'(A_COUNT): rd_mux = tc;
      AW'(A_FLAGS): rd_mux = TW'(flags_q);
      AW'(A_MCFG):  rd_mux = TW'(mcfg_q);
      AW'(A_CCFG):  rd_mux = TW'(ccfg_q);
      default:      rd_mux = '0;
    endcase
    for (int i = 0; i < NMATCH; i++)
      if (hit_addr(bus_addr, A_MR_BASE + i)) rd_mux = mr_q[i];
    for (int j = 0; j < NCAP; j++)
      if (hit_addr(bus_addr, CR_BASE + j)) rd_mux = cr_q[j];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/ptimer_sva.sv
module ptimer_sva #(
  parameter int TW     = 32,
  parameter int NMATCH = 4,
  parameter int NCAP   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [TW-1:0]      tc,
  input logic [TW-1:0]      pc,
  input logic               ctrl_hold,
  input logic               ctrl_en,
  input logic               stop_any,
  input logic [NMATCH-1:0]  hit,
  input logic [NMATCH-1:0]  m_irq,
  input logic [NMATCH-1:0]  mat_out,
  input logic [NCAP-1:0]    cap_evt,
  input logic [TW*NCAP-1:0] cr_flat,
  input logic [NMATCH+NCAP-1:0] flags_q,
  input logic               irq
);
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl_hold |=> (tc == '0 && pc == '0));

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tc == $past(tc) || tc == $past(tc) + TW'(1) || tc == '0));

  p_stop_clears_en_r6: assert property (@(posedge clk) disable iff (rst)
    stop_any |=> !ctrl_en);

  p_match_irq_r8: assert property (@(posedge clk) disable iff (rst)
    |(hit & m_irq) |=> irq);

  p_irq_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (flags_q == '0) |-> !irq);

  for (genvar i = 0; i < NMATCH; i++) begin : g_m
    p_mat_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !hit[i] |=> $stable(mat_out[i]));
  end

  for (genvar j = 0; j < NCAP; j++) begin : g_c
    p_cap_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !cap_evt[j] |=> $stable(cr_flat[TW*j +: TW]));
  end
endmodule

bind ptimer_top ptimer_sva #(.TW(TW), .NMATCH(NMATCH), .NCAP(NCAP)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .tc        (tc),
  .pc        (pc),
  .ctrl_hold (ctrl_hold),
  .ctrl_en   (ctrl_en),
  .stop_any  (stop_any),
  .hit       (hit),
  .m_irq     (m_irq),
  .mat_out   (mat_out),
  .cap_evt   (cap_evt),
  .cr_flat   (cr_flat),
  .flags_q   (flags_q),
  .irq       (irq)
);

// File: tb/ptimer_top_tb.sv
module ptimer_top_tb;
  localparam int TW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [TW-1:0] bus_wdata = '0;
  logic [TW-1:0] bus_rdata;
  logic          count_in = 1'b0;
  logic [3:0]    cap_in = '0;
  logic [3:0]    mat_out;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ptimer_top u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .count_in  (count_in),
    .cap_in    (cap_in),
    .mat_out   (mat_out),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [TW-1:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [TW-1:0] d);
    bus_addr = AW'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  // clear hold, enable, count for n enabled clocks, disable
  task automatic run(input int n);
    wr(0, 32'h2);
    wr(0, 32'h1);
    repeat (n - 1) @(negedge clk);
    wr(0, 32'h0);
  endtask

  task automatic t_reset();
    logic [TW-1:0] d;
    check("R1 mat_out", TW'(mat_out), 0);
    check("R1 irq", TW'(irq), 0);
    rd(0, d);  check("R1 ctrl", d, 0);
    rd(2, d);  check("R1 prescale", d, 0);
    rd(4, d);  check("R1 count", d, 0);
    rd(5, d);  check("R1 flags", d, 0);
    rd(12, d); check("R1 capture0", d, 0);
  endtask

  task automatic t_timer(input int p, input int n);
    logic [TW-1:0] d;
    wr(1, 0);
    wr(2, p);
    rd(2, d); check("R12 prescale readback", d, p);
    run(n);
    rd(4, d); check("R2 count", d, n / (p + 1));
    rd(3, d); check("R2 prescale counter", d, n % (p + 1));
  endtask

  task automatic t_hold();
    logic [TW-1:0] d;
    wr(2, 0);
    run(9);
    wr(0, 32'h3);
    repeat (5) @(negedge clk);
    rd(4, d); check("R4 hold keeps count zero", d, 0);
    wr(0, 32'h0);
  endtask

  task automatic t_counter(input int k);
    logic [TW-1:0] d;
    wr(2, 3);
    wr(1, 32'h1);
    wr(0, 32'h2);
    wr(0, 32'h1);
    for (int i = 0; i < k; i++) begin
      count_in = 1'b1; repeat (2) @(negedge clk);
      count_in = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(0, 32'h0);
    rd(4, d); check("R3 counter mode count", d, k);
    rd(3, d); check("R3 prescale idle", d, 0);
    wr(1, 0);
  endtask

  task automatic t_match_reset();
    logic [TW-1:0] d;
    wr(2, 0);
    wr(8, 4);
    wr(6, 32'h3);            // ch0: irq + reset
    run(42);
    rd(4, d); check("R5 period mr+1", d, 42 % 5);
    check("R8 irq raised", TW'(irq), 1);
    rd(5, d); check("R8 flag bit0", d, 1);
    wr(5, 32'h0);
    rd(5, d); check("R11 zero write keeps flag", d, 1);
    wr(5, 32'h1);
    check("R11 irq cleared", TW'(irq), 0);
    rd(5, d); check("R11 flags cleared", d, 0);
  endtask

  task automatic t_match_stop();
    logic [TW-1:0] d;
    wr(9, 6);
    wr(6, 32'h4 << 5);       // ch1: stop
    run(20);
    rd(4, d); check("R6 count holds match", d, 6);
    rd(0, d); check("R6 enable cleared", d, 0);
    rd(5, d); check("R8 no flag without irq bit", d, 0);
  endtask

  task automatic t_outputs();
    logic [TW-1:0] d;
    wr(10, 2);
    wr(11, 1);
    wr(6, (32'd26 << 10) | (32'd16 << 15));  // ch2 toggle+reset, ch3 high
    run(40);
    check("R7 toggle odd hits", TW'(mat_out[2]), 1);
    check("R7 set high", TW'(mat_out[3]), 1);
    wr(6, (32'd2 << 10) | (32'd8 << 15));    // ch2 none+reset, ch3 low
    run(10);
    check("R7 none keeps", TW'(mat_out[2]), 1);
    check("R7 set low", TW'(mat_out[3]), 0);
    rd(4, d); check("R5 count after 10", d, 10 % 3);
    wr(6, 0);
  endtask

  task automatic pulse_cap(input int j, input logic v);
    cap_in[j] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_capture();
    logic [TW-1:0] d;
    wr(2, 0);
    wr(7, 32'h5 | (32'h2 << 3) | (32'h3 << 6));  // ch0 rise+irq, ch1 fall, ch2 both
    wr(5, 32'hFF);
    run(7);
    pulse_cap(0, 1'b1);
    rd(12, d); check("R9 rise capture", d, 7);
    rd(5, d);  check("R10 capture flag", d, 32'h10);
    pulse_cap(1, 1'b1);
    rd(13, d); check("R9 rise ignored on fall-only", d, 0);
    pulse_cap(3, 1'b1);
    rd(15, d); check("R9 disabled channel", d, 0);
    run(12);
    pulse_cap(1, 1'b0);
    rd(13, d); check("R9 fall capture", d, 12);
    pulse_cap(2, 1'b1);
    rd(14, d); check("R9 both rise", d, 12);
    run(3);
    pulse_cap(2, 1'b0);
    rd(14, d); check("R9 both fall", d, 3);
    pulse_cap(0, 1'b0);
    rd(12, d); check("R9 fall ignored on rise-only", d, 7);
    rd(5, d);  check("R10 no flag without irq bit", d, 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_timer(3, 40);
    t_timer(0, 25);
    t_timer(6, 30);
    t_hold();
    t_counter(5);
    t_match_reset();
    t_match_stop();
    t_outputs();
    t_capture();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule